// File: doc/BRIEF.md
# Overlapped Round-Robin Bus Grant Arbiter

This block is the central arbiter of a shared bus. Each master has a private request input and a private grant output that run straight to the arbiter, so there are no shared arbitration wires. A bus use runs in a fixed order: the master requests, it is granted, it drives an address phase and one or more data phases, and then it releases the bus. The arbiter makes its choice for the next owner during the current owner's final data phase. The new grant is then visible in the first cycle after that phase, and the handover costs no extra cycles.

Masters are served in a rotating order. The search starts one index past the master that was granted most recently and moves up through the indices, wrapping at the top. Among the waiting requesters, the one nearest above the previous owner wins. The previous owner comes last, so no requester can be locked out. When nobody is requesting, the grant stays parked on the last owner. A granted master that leaves the bus idle for too long loses its grant.

Top module: `bus_grant_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set in every cycle. Bit i is the grant for the master on `req_i` bit i. During reset and in the first cycle after it, `gnt_o` is all zero.
- R2: A grant is only ever given to a master whose request bit was high in the cycle the choice was made.
- R3: The grant holds its value while the bus is busy. Busy means `bus_idle_i` is 0 and `last_phase_i` is 0. This holds whatever `req_i` does.
- R4: When `last_phase_i` is high and at least one request is pending, the chosen master's grant appears in the very next cycle.
- R5: The search starts at index (previous grantee + 1) mod N and moves up through the indices, wrapping at the top. After reset it starts at index 0. The first requesting index found is granted, so the previous grantee has the lowest priority.
- R6: When all masters request on every handover, N consecutive handovers grant every master exactly once, in ascending order with wrap-around.
- R7: With no request pending, the grant stays on its current owner, both at a last phase and on an idle bus.
- R8: When the bus is idle and the current owner keeps its request high, the owner keeps its grant for TIMEOUT cycles (16 by default).
- R9: When the TIMEOUT count of idle cycles is reached, the grant drops to zero. It is then arbitrated again with the search starting one past the master that timed out.
- R10: When the bus is idle and the owner has dropped its request, the grant moves to the next pending requester in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| req_i | input | N | One request bit per master |
| bus_idle_i | input | 1 | No transaction is running on the bus |
| last_phase_i | input | 1 | The current owner is in its final data phase |
| gnt_o | output | N | One-hot grant, or zero |

## Verification
The hardest case to reach is rotation from every possible previous owner. The search pointer has no port, so the bench sets it indirectly. For each owner index it first grants that master alone with a one-hot request at a last phase. It then applies all fifteen non-empty request patterns at the next handover and predicts the winner from the modular search order. The idle timeout is reached by holding one master's request on an idle bus and counting the cycles until its grant drops. A two-master request pattern is then applied to show where the search restarts.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_PICK = 2'd1,
        ACT_DROP = 2'd2
    } arb_act_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] ptr_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] upper_mask;
    logic [N-1:0] upper_req;

    for (genvar g = 0; g < N; g++) begin : g_mask
        assign upper_mask[g] = (IW'(g) >= ptr_i);
    end

    assign upper_req = req_i & upper_mask;

    always_comb begin
        idx_o   = '0;
        valid_o = |req_i;
        if (|upper_req) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (upper_req[i]) idx_o = IW'(i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req_i[i]) idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/arb_idle_timer.sv
module arb_idle_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic expired_o
);

    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = tick_i && (cnt_q == CW'(TIMEOUT - 1));
        if (!tick_i || expired_o) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter
    import arb_pkg::*;
#(
    parameter int N       = 4,
    parameter int TIMEOUT = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    input  logic         bus_idle_i,
    input  logic         last_phase_i,
    output logic [N-1:0] gnt_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]  gnt;
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic          pick_vld;
    logic [IW-1:0] pick_idx;
    logic          owned;
    logic          owner_req;
    logic          wait_tick;
    logic          expired;
    arb_act_e      act;

    arb_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req_i   (req_i),
        .ptr_i   (st_q.ptr),
        .valid_o (pick_vld),
        .idx_o   (pick_idx)
    );

    assign owned     = |st_q.gnt;
    assign owner_req = |(st_q.gnt & req_i);
    assign wait_tick = bus_idle_i && !last_phase_i && owned && owner_req;

    arb_idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (wait_tick),
        .expired_o (expired)
    );

    always_comb begin
        if (last_phase_i)    act = ACT_PICK;
        else if (wait_tick)  act = expired ? ACT_DROP : ACT_HOLD;
        else if (bus_idle_i) act = ACT_PICK;
        else                 act = ACT_HOLD;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_PICK: begin
                if (pick_vld) begin
                    st_d.gnt = '0;
                    st_d.gnt[pick_idx] = 1'b1;
                    st_d.ptr = (pick_idx == IW'(N - 1)) ? '0 : pick_idx + 1'b1;
                end
            end
            ACT_DROP: st_d.gnt = '0;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign gnt_o = st_q.gnt;

    // R1
    p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    // R2
    p_to_requester_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o != $past(gnt_o) && gnt_o != '0) |-> (($past(req_i) & gnt_o) != '0));

    // R3
    p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_idle_i && !last_phase_i) |=> $stable(gnt_o));

    // R3
    p_change_point_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o != $past(gnt_o)) |-> $past(bus_idle_i || last_phase_i));

    // R7
    p_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == '0) |=> $stable(gnt_o));

    // R9
    p_drop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o == '0 && $past(gnt_o) != '0) |-> $past(bus_idle_i && !last_phase_i));

endmodule

// File: tb/tb_bus_grant_arbiter.sv
module tb_bus_grant_arbiter;

    localparam int N  = 4;
    localparam int TO = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         idle = 1'b0;
    logic         last = 1'b0;
    logic [N-1:0] gnt;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bus_grant_arbiter #(.N(N), .TIMEOUT(TO)) dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_i        (req),
        .bus_idle_i   (idle),
        .last_phase_i (last),
        .gnt_o        (gnt)
    );

    task automatic check(input logic [N-1:0] exp, input string tag);
        checks++;
        if (gnt !== exp) begin
            errors++;
            $display("FAIL %s: gnt actual=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic i, input logic l,
                        input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        req = r; idle = i; last = l;
        @(posedge clk);
        #1;
        check(exp, tag);
    endtask

    function automatic logic [N-1:0] rr_expect(input int prev, input logic [N-1:0] pat);
        for (int j = 1; j <= N; j++) begin
            int m;
            m = (prev + j) % N;
            if (pat[m]) return N'(1) << m;
        end
        return '0;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check('0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        step('0, 1'b0, 1'b0, '0, "R1 after reset");

        // R5: first grant after reset searches from index 0
        step(4'b1010, 1'b0, 1'b1, 4'b0010, "R5 post-reset");

        // R5 sweep over previous owner and every pattern; R3 busy hold
        for (int p = 0; p < N; p++) begin
            for (int pat = 1; pat < (1 << N); pat++) begin
                logic [N-1:0] e;
                step(N'(1) << p, 1'b0, 1'b1, N'(1) << p, "R4 handover");
                e = rr_expect(p, N'(pat));
                step(N'(pat), 1'b0, 1'b1, e, "R5 rotation");
                step(~N'(pat), 1'b0, 1'b0, e, "R3 busy hold");
            end
        end

        // R6: all requesting, grants rotate through everyone
        step(4'b1000, 1'b0, 1'b1, 4'b1000, "R4 handover");
        for (int k = 0; k < 2 * N; k++) begin
            step('1, 1'b0, 1'b1, N'(1) << (k % N), "R6 bounded wait");
        end

        // R7: parking (last owner is 3)
        step('0, 1'b0, 1'b1, 4'b1000, "R7 park at last phase");
        step('0, 1'b1, 1'b0, 4'b1000, "R7 park on idle");

        // R8 / R9: idle hold then timeout
        step(4'b0010, 1'b0, 1'b1, 4'b0010, "R4 handover");
        for (int k = 1; k < TO; k++) begin
            step(4'b0010, 1'b1, 1'b0, 4'b0010, "R8 idle hold");
        end
        step(4'b0010, 1'b1, 1'b0, 4'b0000, "R9 timeout drop");
        step(4'b0011, 1'b1, 1'b0, 4'b0001, "R9 restart past timed-out owner");
        step(4'b0011, 1'b0, 1'b0, 4'b0001, "R3 busy hold");

        // R10: owner withdraws on an idle bus
        step(4'b0100, 1'b0, 1'b1, 4'b0100, "R4 handover");
        step(4'b1001, 1'b1, 1'b0, 4'b1000, "R10 owner withdrew");
        step(4'b0001, 1'b0, 1'b0, 4'b1000, "R3 busy hold");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule